// File: doc/BRIEF.md
# Block-Transfer Address and Length Engine

This block is the address and count datapath of a simple block-transfer adapter on a 16-bit bus whose address and data lines are active-low. It keeps a memory or device address and a block-length count. Each one is loaded in parallel from the data bus through its own active-low load strobe. Every transfer pulse moves one byte: the address goes up by one and the length goes down by one.

The address counter is a chain of 4-bit nibble counters joined by carries. A registered `done` flag rises when the address reaches all ones or the length reaches zero. While `done` is high, transfer pulses are blocked inside the block. Address bit 0 does not exist on the bus. Bits 15 to 1 are passed on, registered, for device-number recognition. Bits 2 and 1 select which internal register a read cycle places on the data bus.

On request, the block drives the held address onto the address bus one cycle later. All bus outputs are inverted back to active-low. A bus whose enable is low idles at all ones. Sequencing, arbitration and memory timing belong to the surrounding control logic.

Top module: `bt_addr_len_engine`

## Requirements
- R1: After synchronous reset the address is 0x0000, the length is 0x0000 and `done` is 1. Both output enables are 0 and both output buses read all ones.
- R2: One cycle after any edge, `dev_num_o` equals the inverted `bus_addr_n_i` (bits 15..1) sampled at that edge. Address bit 0 is never received.
- R3: When `ld_addr_n` is 0 at an edge, the address takes the inverted `bus_data_n_i`. This load wins over a transfer pulse in the same cycle.
- R4: An unblocked transfer pulse adds one to the address. Every nibble that is at 15 when the carry reaches it wraps to 0, and the carry moves up to the next nibble.
- R5: When `ld_len_n` is 0 at an edge, the length takes the inverted `bus_data_n_i`. This load wins over a decrement in the same cycle.
- R6: An unblocked transfer pulse subtracts one from the length.
- R7: After every edge, `done` equals (address == 0xFFFF) OR (length == 0) for the register values of that edge. A reload that leaves both conditions false clears it.
- R8: While `done` is 1, a transfer pulse changes neither the address nor the length. The address never wraps past 0xFFFF and the length never wraps below 0.
- R9: When `addr_drive` is 1 at an edge, the next cycle shows `bus_addr_oe` = 1 and `bus_addr_n_o` = inverted address as held before that edge. Otherwise `bus_addr_oe` = 0 and `bus_addr_n_o` is all ones.
- R10: When `rd_cycle` is 1 at an edge, the next cycle shows `bus_data_oe` = 1 and `bus_data_n_o` = the inverted selected word. The select is the inverted address bits 2..1: 0 gives the address, 1 the length, 2 a status word (bit 0 = address all ones, bit 1 = length zero, other bits 0), and 3 gives zero. Otherwise `bus_data_oe` = 0 and `bus_data_n_o` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr_n_i | input | 15 | Received address bus bits 15..1, active-low |
| bus_addr_n_o | output | 16 | Driven address bus, active-low, registered |
| bus_addr_oe | output | 1 | Address bus drive enable, registered |
| bus_data_n_i | input | 16 | Received data bus, active-low |
| bus_data_n_o | output | 16 | Readback data, active-low, registered |
| bus_data_oe | output | 1 | Data bus drive enable, registered |
| ld_addr_n | input | 1 | Address parallel load strobe, active-low |
| ld_len_n | input | 1 | Length parallel load strobe, active-low |
| xfer_pulse | input | 1 | One-cycle transfer pulse, one per byte |
| addr_drive | input | 1 | Request to drive the address onto the bus |
| rd_cycle | input | 1 | Register read cycle |
| dev_num_o | output | 15 | Received address bits 15..1, active-high, registered |
| done | output | 1 | Terminal flag: address saturated or length zero |

## Verification
Two functions can fall in the same cycle: a parallel load and a transfer pulse. The bench issues address loads and length loads on the same edge as an unblocked pulse. It then reads back both registers, to show that the loaded value survives and that the register without a load still steps. Readback cycles also run on the same edges as pulses. Those are judged against the register values held before the edge, which is the value the mux sees.

// File: rtl/bt_pkg.sv
package bt_pkg;
  localparam int NIB_W = 4;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_LEN  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_ZERO = 2'd3
  } rb_sel_e;

  localparam int STAT_SAT_BIT  = 0;
  localparam int STAT_ZERO_BIT = 1;
endpackage

// File: rtl/bt_nibble_cnt.sv
module bt_nibble_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] ld_val,
  input  logic         cin,
  output logic [W-1:0] q,
  output logic         cout
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= ld_val;
    else if (cin)  q <= q + 1'b1;
  end

  assign cout = cin & (&q);
endmodule

// File: rtl/bt_addr_counter.sv
module bt_addr_counter #(
  parameter int W     = 16,
  parameter int NIB_W = bt_pkg::NIB_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] ld_val,
  input  logic         adv,
  output logic [W-1:0] q,
  output logic         sat_nxt
);
  localparam int NIBS = W / NIB_W;

  logic [NIBS:0]  carry;
  logic [W-1:0]   nxt;

  assign carry[0] = adv;

  for (genvar i = 0; i < NIBS; i++) begin : g_nib
    bt_nibble_cnt #(.W(NIB_W)) u_nib (
      .clk    (clk),
      .rst    (rst),
      .load   (load),
      .ld_val (ld_val[i*NIB_W +: NIB_W]),
      .cin    (carry[i]),
      .q      (q[i*NIB_W +: NIB_W]),
      .cout   (carry[i+1])
    );
  end

  always_comb begin
    if (load)     nxt = ld_val;
    else if (adv) nxt = q + 1'b1;
    else          nxt = q;
  end

  assign sat_nxt = &nxt;

  // R4: one step per unblocked pulse
  a_r4_addr_step: assert property (@(posedge clk) disable iff (rst)
    (adv && !load) |=> (q == $past(q) + 1'b1));

  // R3: parallel load wins
  a_r3_addr_load: assert property (@(posedge clk) disable iff (rst)
    load |=> (q == $past(ld_val)));

  // R8: carry never leaves the top nibble
  a_r8_no_addr_overflow: assert property (@(posedge clk) disable iff (rst)
    !carry[NIBS]);
endmodule

// File: rtl/bt_len_counter.sv
module bt_len_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] ld_val,
  input  logic         dec,
  output logic [W-1:0] q,
  output logic         zero_nxt
);
  logic [W-1:0] nxt;

  always_comb begin
    if (load)     nxt = ld_val;
    else if (dec) nxt = q - 1'b1;
    else          nxt = q;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  assign zero_nxt = (nxt == '0);

  // R6: one decrement per unblocked pulse
  a_r6_len_step: assert property (@(posedge clk) disable iff (rst)
    (dec && !load) |=> (q == $past(q) - 1'b1));

  // R5: parallel load wins
  a_r5_len_load: assert property (@(posedge clk) disable iff (rst)
    load |=> (q == $past(ld_val)));

  // R8: never decrement from zero
  a_r8_no_len_underflow: assert property (@(posedge clk) disable iff (rst)
    (dec && !load) |-> (q != '0));
endmodule

// File: rtl/bt_readback_mux.sv
module bt_readback_mux #(
  parameter int W = 16
) (
  input  bt_pkg::rb_sel_e sel,
  input  logic [W-1:0]    addr,
  input  logic [W-1:0]    len,
  input  logic            sat,
  input  logic            zero,
  output logic [W-1:0]    word
);
  import bt_pkg::*;

  logic [W-1:0] stat;

  always_comb begin
    stat                = '0;
    stat[STAT_SAT_BIT]  = sat;
    stat[STAT_ZERO_BIT] = zero;
  end

  always_comb begin
    unique case (sel)
      SEL_ADDR: word = addr;
      SEL_LEN:  word = len;
      SEL_STAT: word = stat;
      default:  word = '0;
    endcase
  end
endmodule

// File: rtl/bt_addr_len_engine.sv
module bt_addr_len_engine #(
  parameter int BUS_W = 16,
  parameter int NIB_W = bt_pkg::NIB_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BUS_W-1:1] bus_addr_n_i,
  output logic [BUS_W-1:0] bus_addr_n_o,
  output logic             bus_addr_oe,
  input  logic [BUS_W-1:0] bus_data_n_i,
  output logic [BUS_W-1:0] bus_data_n_o,
  output logic             bus_data_oe,
  input  logic             ld_addr_n,
  input  logic             ld_len_n,
  input  logic             xfer_pulse,
  input  logic             addr_drive,
  input  logic             rd_cycle,
  output logic [BUS_W-2:0] dev_num_o,
  output logic             done
);
  import bt_pkg::*;

  localparam int LEN_W = BUS_W;

  logic [BUS_W-1:0] din;
  logic [BUS_W-1:1] ain;
  logic [BUS_W-1:0] addr_q;
  logic [LEN_W-1:0] len_q;
  logic             adv, ld_a, ld_l;
  logic             sat_nxt, zero_nxt;
  logic [BUS_W-1:0] rb_word;
  rb_sel_e          sel;

  assign din  = ~bus_data_n_i;
  assign ain  = ~bus_addr_n_i;
  assign ld_a = ~ld_addr_n;
  assign ld_l = ~ld_len_n;
  assign adv  = xfer_pulse & ~done;
  assign sel  = rb_sel_e'(ain[2:1]);

  bt_addr_counter #(.W(BUS_W), .NIB_W(NIB_W)) u_addr (
    .clk     (clk),
    .rst     (rst),
    .load    (ld_a),
    .ld_val  (din),
    .adv     (adv),
    .q       (addr_q),
    .sat_nxt (sat_nxt)
  );

  bt_len_counter #(.W(LEN_W)) u_len (
    .clk      (clk),
    .rst      (rst),
    .load     (ld_l),
    .ld_val   (din[LEN_W-1:0]),
    .dec      (adv),
    .q        (len_q),
    .zero_nxt (zero_nxt)
  );

  bt_readback_mux #(.W(BUS_W)) u_mux (
    .sel  (sel),
    .addr (addr_q),
    .len  (len_q),
    .sat  (&addr_q),
    .zero (len_q == '0),
    .word (rb_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done         <= 1'b1;
      bus_addr_oe  <= 1'b0;
      bus_addr_n_o <= '1;
      bus_data_oe  <= 1'b0;
      bus_data_n_o <= '1;
      dev_num_o    <= '0;
    end else begin
      done         <= sat_nxt | zero_nxt;
      bus_addr_oe  <= addr_drive;
      bus_addr_n_o <= addr_drive ? ~addr_q : '1;
      bus_data_oe  <= rd_cycle;
      bus_data_n_o <= rd_cycle ? ~rb_word : '1;
      dev_num_o    <= ain;
    end
  end

  // R7: terminal flag tracks both register conditions
  a_r7_done_flags: assert property (@(posedge clk) disable iff (rst)
    done == ((&addr_q) || (len_q == '0)));

  // R8: blocked pulses leave both registers alone
  a_r8_hold_when_done: assert property (@(posedge clk) disable iff (rst)
    (done && ld_addr_n && ld_len_n) |=> ($stable(addr_q) && $stable(len_q)));

  // R9: address drive shows the held address
  a_r9_addr_drive: assert property (@(posedge clk) disable iff (rst)
    addr_drive |=> (bus_addr_oe && (bus_addr_n_o == ~$past(addr_q))));

  // R10: idle data bus when no read cycle
  a_r10_data_idle: assert property (@(posedge clk) disable iff (rst)
    !rd_cycle |=> (!bus_data_oe && (bus_data_n_o == '1)));
endmodule

// File: tb/sim_bt_addr_len_engine.sv
`timescale 1ns/1ps
module sim_bt_addr_len_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:1] bus_addr_n_i = '1;
  logic [15:0] bus_addr_n_o;
  logic        bus_addr_oe;
  logic [15:0] bus_data_n_i = '1;
  logic [15:0] bus_data_n_o;
  logic        bus_data_oe;
  logic        ld_addr_n = 1'b1;
  logic        ld_len_n = 1'b1;
  logic        xfer_pulse = 1'b0;
  logic        addr_drive = 1'b0;
  logic        rd_cycle = 1'b0;
  logic [14:0] dev_num_o;
  logic        done;

  always #2 clk = ~clk;

  bt_addr_len_engine u0 (
    .clk(clk), .rst(rst),
    .bus_addr_n_i(bus_addr_n_i), .bus_addr_n_o(bus_addr_n_o), .bus_addr_oe(bus_addr_oe),
    .bus_data_n_i(bus_data_n_i), .bus_data_n_o(bus_data_n_o), .bus_data_oe(bus_data_oe),
    .ld_addr_n(ld_addr_n), .ld_len_n(ld_len_n), .xfer_pulse(xfer_pulse),
    .addr_drive(addr_drive), .rd_cycle(rd_cycle), .dev_num_o(dev_num_o), .done(done)
  );

  typedef struct {
    string       tag;
    logic        done;
    logic        aoe;
    logic [15:0] an;
    logic        doe;
    logic [15:0] dn;
    logic [14:0] dev;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   mon_on = 1'b0;

  logic [15:0] m_addr, m_len;
  logic        m_done;

  task automatic chk(string tag, string req, logic [15:0] act, logic [15:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s (%s): actual %h expected %h", req, tag, act, expv);
    end
  endtask

  // monitor: pops one expected item per clock, away from the edge
  always @(posedge clk) begin
    #1;
    if (mon_on && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk(e.tag, "R7 done", {15'd0, done}, {15'd0, e.done});
      chk(e.tag, "R9 addr oe", {15'd0, bus_addr_oe}, {15'd0, e.aoe});
      chk(e.tag, "R9 addr bus", bus_addr_n_o, e.an);
      chk(e.tag, "R10 data oe", {15'd0, bus_data_oe}, {15'd0, e.doe});
      chk(e.tag, "R10 data bus", bus_data_n_o, e.dn);
      chk(e.tag, "R2 dev num", {1'b0, dev_num_o}, {1'b0, e.dev});
    end
  end

  // driver: one cycle of stimulus, expected outputs computed from the requirements
  task automatic cyc(string tag, bit la, bit ll, logic [15:0] dval, bit p,
                     bit drv, bit rd, logic [15:0] aval);
    exp_t        e;
    logic [15:0] word;
    logic        adv;
    @(negedge clk);
    ld_addr_n    = ~la;
    ld_len_n     = ~ll;
    bus_data_n_i = ~dval;
    xfer_pulse   = p;
    addr_drive   = drv;
    rd_cycle     = rd;
    bus_addr_n_i = ~aval[15:1];
    case (aval[2:1])
      2'd0: word = m_addr;
      2'd1: word = m_len;
      2'd2: word = {14'd0, (m_len == 16'd0), (m_addr == 16'hFFFF)};
      default: word = 16'd0;
    endcase
    adv = p && !m_done;
    if (la)       m_addr = dval;
    else if (adv) m_addr = m_addr + 16'd1;
    if (ll)       m_len = dval;
    else if (adv) m_len = m_len - 16'd1;
    m_done = (m_addr == 16'hFFFF) || (m_len == 16'd0);
    e.tag  = tag;
    e.done = m_done;
    e.aoe  = drv;
    e.doe  = rd;
    e.dn   = rd ? ~word : 16'hFFFF;
    e.dev  = aval[15:1];
    exp_q.push_back(e);
    e.an   = 16'hFFFF;
  endtask

  // the address drive expectation needs the pre-edge address; wrapper fixes it
  task automatic cyc2(string tag, bit la, bit ll, logic [15:0] dval, bit p,
                      bit drv, bit rd, logic [15:0] aval);
    logic [15:0] pre;
    pre = m_addr;
    cyc(tag, la, ll, dval, p, drv, rd, aval);
    exp_q[exp_q.size()-1].an = drv ? ~pre : 16'hFFFF;
  endtask

  initial begin
    #800000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    m_addr = 16'd0; m_len = 16'd0; m_done = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    mon_on = 1'b1;
    // R1: reset values through readback
    cyc2("R1 idle",        0, 0, 16'h0000, 0, 0, 0, 16'h0000);
    cyc2("R1 read addr",   0, 0, 16'h0000, 0, 0, 1, 16'h0000);
    cyc2("R1 read len",    0, 0, 16'h0000, 0, 0, 1, 16'h0002);
    cyc2("R1 read stat",   0, 0, 16'h0000, 0, 0, 1, 16'h0004);
    cyc2("R10 read zero",  0, 0, 16'h0000, 0, 0, 1, 16'h0006);
    // R8: pulse while done at reset is blocked
    cyc2("R8 pulse after reset", 0, 0, 16'h0000, 1, 0, 1, 16'h0000);
    // R3/R5 loads
    cyc2("R3 load addr",   1, 0, 16'h00FE, 0, 0, 0, 16'h0000);
    cyc2("R5 load len",    0, 1, 16'h0005, 0, 0, 1, 16'h0000);
    cyc2("R7 done clear",  0, 0, 16'h0000, 0, 0, 1, 16'h0004);
    // R4/R6 pulses with nibble carries, readback in same cycle
    cyc2("R4 pulse 1",     0, 0, 16'h0000, 1, 0, 1, 16'h0000);
    cyc2("R4 pulse carry", 0, 0, 16'h0000, 1, 1, 1, 16'h0002);
    cyc2("R4 read addr",   0, 0, 16'h0000, 0, 1, 1, 16'h0001);
    cyc2("R2 bit0 ignored",0, 0, 16'h0000, 0, 0, 1, 16'hA5A2);
    cyc2("R2 bit0 set",    0, 0, 16'h0000, 0, 0, 1, 16'hA5A3);
    // R3 priority: load with pulse in same cycle
    cyc2("R3 load wins",   1, 0, 16'h0FFF, 1, 0, 1, 16'h0002);
    cyc2("R4 triple carry",0, 0, 16'h0000, 1, 1, 1, 16'h0000);
    cyc2("R4 read",        0, 0, 16'h0000, 0, 1, 1, 16'h0000);
    // R5 priority: length load with pulse
    cyc2("R5 load wins",   0, 1, 16'h0003, 1, 0, 1, 16'h0000);
    cyc2("R6 dec",         0, 0, 16'h0000, 1, 0, 1, 16'h0002);
    cyc2("R6 dec",         0, 0, 16'h0000, 1, 0, 1, 16'h0002);
    cyc2("R7 len zero",    0, 0, 16'h0000, 1, 0, 1, 16'h0004);
    cyc2("R8 blocked len", 0, 0, 16'h0000, 1, 1, 1, 16'h0002);
    cyc2("R8 blocked addr",0, 0, 16'h0000, 1, 1, 1, 16'h0000);
    // address saturation path
    cyc2("R5 reload len",  0, 1, 16'h0100, 0, 0, 0, 16'h0000);
    cyc2("R3 load high",   1, 0, 16'hFFFD, 0, 0, 1, 16'h0004);
    cyc2("R4 to FFFE",     0, 0, 16'h0000, 1, 1, 1, 16'h0000);
    cyc2("R7 to FFFF",     0, 0, 16'h0000, 1, 1, 1, 16'h0000);
    cyc2("R8 sat blocked", 0, 0, 16'h0000, 1, 1, 1, 16'h0004);
    cyc2("R8 sat blocked", 0, 0, 16'h0000, 1, 1, 1, 16'h0002);
    cyc2("R7 reload clears",1,0, 16'h1234, 1, 0, 1, 16'h0004);
    cyc2("R9 drive",       0, 0, 16'h0000, 0, 1, 1, 16'h0004);
    cyc2("R9 idle",        0, 0, 16'h0000, 0, 0, 0, 16'hFFFE);
    // both loads together, pulse ignored
    cyc2("R3 R5 both load",1, 1, 16'h00F0, 1, 0, 0, 16'h0000);
    cyc2("R10 read addr",  0, 0, 16'h0000, 0, 1, 1, 16'h0000);
    cyc2("R10 read len",   0, 0, 16'h0000, 0, 0, 1, 16'h0002);
    cyc2("R10 idle",       0, 0, 16'h0000, 0, 0, 0, 16'h0000);
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule